// File: doc/BRIEF.md
# SDI Serial NRZI Decoder and Descrambler

This block is one stage of the bit-serial receive path for standard-definition serial digital video. It accepts one recovered line bit per clock, qualified by a valid strobe. It first undoes the polarity-free NRZI line coding, where each NRZ bit is the XOR of the current and previous line bits (polynomial x+1). It then removes the self-synchronizing scrambling, where each data bit is the XOR of the NRZ bit with the NRZ bits four and nine positions earlier (polynomial x^9+x^4+1). Both stages derive their state from the received stream alone. After enough bits have been seen, the output matches the original serial data whatever state the far-end encoder started in and whatever the absolute polarity of the line.

A bypass input turns the block into a plain registered pass-through. This serves streams that are neither scrambled nor NRZI coded. The pass-through has the same one-clock latency as the decode path, so bit alignment does not shift when the mode changes. Each accepted input bit produces exactly one output beat on the clock edge after it is accepted. The history registers advance only on accepted bits. Clock recovery, equalization, slicing and word framing belong to other blocks.

Top module: `sdi_nrzi_descrambler`

## Requirements
- R1: While reset is high and on the first cycle after it, out_valid and out_bit are 0. Reset restarts the fill count.
- R2: With bypass low, the output bit for the k-th accepted bit since reset or bypass exit, for k >= 11, equals the original data bit. That data bit was scrambled as s[n] = d[n] ^ s[n-4] ^ s[n-9] and then NRZI coded as t[n] = t[n-1] ^ s[n].
- R3: Latency is one clock. A bit accepted at a rising edge (in_valid high) is presented on out_bit with out_valid after that same edge, once the fill count is reached or while bypass is high.
- R4: After reset, or after bypass goes from 1 to 0, out_valid stays low for the first 10 accepted bits. It goes high with the 11th.
- R5: A cycle with in_valid low produces out_valid low on the next cycle and leaves out_bit unchanged. No history advances, so decoding continues correctly across gaps.
- R6: With bypass high, out_bit is in_bit from the previous edge and out_valid is in_valid from the previous edge, with no fill wait.
- R7: Decoded data does not depend on line polarity. Inverting every line bit, or starting the encoder from any initial state, gives the same output from the 11th bit on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock |
| rst | input | 1 | Synchronous reset, active high |
| in_bit | input | 1 | Recovered serial line bit |
| in_valid | input | 1 | Qualifies in_bit on this cycle |
| bypass | input | 1 | High: pass line bits through without decoding |
| out_bit | output | 1 | Decoded (or passed) serial bit |
| out_valid | output | 1 | Qualifies out_bit |

## Verification
The bench builds the block with its default parameters. These are a nine-bit history with the middle tap at four, the only setting that matches the video scrambling polynomial, and they give a fill length of ten bits. With that fill length, the warm-up boundary after reset and after bypass exit can be checked bit by bit. The default setting also lets a matching scrambler-plus-NRZI model in the bench start from several encoder states and both line polarities within a few hundred cycles. Streams with regular gaps in the valid strobe, bypass runs and a mid-stream reset are all reachable in the same run.

// File: rtl/sdi_rx_pkg.sv
package sdi_rx_pkg;

    // Scrambler history length and the inner tap position (x^9 + x^4 + 1)
    localparam int SCR_ORDER_DEF = 9;
    localparam int SCR_TAP_DEF   = 4;

    // One registered output beat
    typedef struct packed {
        logic data;
        logic valid;
    } serial_beat_t;

    // NRZI (x + 1) decode of one bit
    function automatic logic nrzi_decode(input logic cur_line, input logic prev_line);
        return cur_line ^ prev_line;
    endfunction

    // Three-term descramble of one bit
    function automatic logic descramble_bit(input logic nrz,
                                            input logic nrz_mid,
                                            input logic nrz_far);
        return nrz ^ nrz_mid ^ nrz_far;
    endfunction

endpackage

// File: rtl/sdi_nrzi_stage.sv
module sdi_nrzi_stage
    import sdi_rx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic line_bit,
    output logic nrz_bit
);

    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
        end else if (adv) begin
            prev_q <= line_bit;
        end
    end

    assign nrz_bit = nrzi_decode(line_bit, prev_q);

endmodule

// File: rtl/sdi_descram_stage.sv
module sdi_descram_stage
    import sdi_rx_pkg::*;
#(
    parameter int ORDER = SCR_ORDER_DEF,
    parameter int TAP   = SCR_TAP_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic nrz_bit,
    output logic data_bit
);

    // hist_q[i] holds the NRZ bit received i+1 accepted bits ago
    logic [ORDER-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else if (adv) begin
            hist_q <= {hist_q[ORDER-2:0], nrz_bit};
        end
    end

    assign data_bit = descramble_bit(nrz_bit, hist_q[TAP-1], hist_q[ORDER-1]);

endmodule

// File: rtl/sdi_fill_tracker.sv
module sdi_fill_tracker #(
    parameter int FILL = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic adv,
    output logic full
);

    localparam int CW = $clog2(FILL + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (adv && !full) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign full = (cnt_q == CW'(FILL));

endmodule

// File: rtl/sdi_nrzi_descrambler.sv
module sdi_nrzi_descrambler
    import sdi_rx_pkg::*;
#(
    parameter int HIST_LEN = SCR_ORDER_DEF,
    parameter int MID_TAP  = SCR_TAP_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic in_bit,
    input  logic in_valid,
    input  logic bypass,
    output logic out_bit,
    output logic out_valid
);

    // One line bit for NRZI history plus HIST_LEN NRZ bits
    localparam int FILL_BITS = HIST_LEN + 1;

    logic nrz_bit;
    logic data_bit;
    logic hist_full;
    serial_beat_t beat_q;

    sdi_nrzi_stage u_nrzi (
        .clk      (clk),
        .rst      (rst),
        .adv      (in_valid),
        .line_bit (in_bit),
        .nrz_bit  (nrz_bit)
    );

    sdi_descram_stage #(
        .ORDER (HIST_LEN),
        .TAP   (MID_TAP)
    ) u_descram (
        .clk      (clk),
        .rst      (rst),
        .adv      (in_valid),
        .nrz_bit  (nrz_bit),
        .data_bit (data_bit)
    );

    sdi_fill_tracker #(
        .FILL (FILL_BITS)
    ) u_fill (
        .clk   (clk),
        .rst   (rst),
        .clear (bypass),
        .adv   (in_valid),
        .full  (hist_full)
    );

    // Shared output register: both modes see exactly one clock of latency
    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
        end else begin
            beat_q.valid <= in_valid && (bypass || hist_full);
            if (in_valid) begin
                beat_q.data <= bypass ? in_bit : data_bit;
            end
        end
    end

    assign out_bit   = beat_q.data;
    assign out_valid = beat_q.valid;

endmodule

// File: rtl/sdi_nrzi_descrambler_chk.sv
module sdi_nrzi_descrambler_chk #(
    parameter int HIST_LEN = 9
) (
    input logic clk,
    input logic rst,
    input logic in_bit,
    input logic in_valid,
    input logic bypass,
    input logic out_bit,
    input logic out_valid
);

    localparam int FILL = HIST_LEN + 1;
    localparam int CW   = $clog2(FILL + 1);

    logic [CW-1:0] seen_q;
    logic          rst_q = 1'b0;

    // Independent count of accepted decode-mode bits since reset or bypass
    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst || bypass) begin
            seen_q <= '0;
        end else if (in_valid && seen_q != CW'(FILL)) begin
            seen_q <= seen_q + 1'b1;
        end
    end

    always @(posedge clk) begin
        if (rst_q === 1'b1) begin
            AST_RESET_QUIET: assert (!out_valid && !out_bit); // R1
        end
    end

    AST_STALL_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R5

    AST_STALL_HOLDS_BIT: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_bit)); // R5

    AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (rst)
        (bypass && in_valid) |=> (out_valid && out_bit == $past(in_bit))); // R6

    AST_FILL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (!bypass && in_valid && seen_q != CW'(FILL)) |=> !out_valid); // R4

    AST_FILLED_EMITS: assert property (@(posedge clk) disable iff (rst)
        (!bypass && in_valid && seen_q == CW'(FILL)) |=> out_valid); // R3

    AST_EXIT_REFILL: assert property (@(posedge clk) disable iff (rst)
        $fell(bypass) |=> !out_valid); // R4

endmodule

bind sdi_nrzi_descrambler sdi_nrzi_descrambler_chk #(.HIST_LEN(HIST_LEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_bit    (in_bit),
    .in_valid  (in_valid),
    .bypass    (bypass),
    .out_bit   (out_bit),
    .out_valid (out_valid)
);

// File: tb/sdi_nrzi_descrambler_tb.sv
module sdi_nrzi_descrambler_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_bit = 1'b0;
    logic in_valid = 1'b0;
    logic bypass = 1'b0;
    logic out_bit;
    logic out_valid;

    int n_checks = 0;
    int n_fail   = 0;

    // Encoder model state: scrambler history and NRZI line level
    logic [8:0] enc_sh;
    logic       enc_line;
    logic [15:0] prng;

    always #2 clk = ~clk;

    sdi_nrzi_descrambler u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_bit    (in_bit),
        .in_valid  (in_valid),
        .bypass    (bypass),
        .out_bit   (out_bit),
        .out_valid (out_valid)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Drive one cycle and sample shortly after the capturing edge
    task automatic push(input logic b, input logic v, input logic byp);
        @(negedge clk);
        in_bit   = b;
        in_valid = v;
        bypass   = byp;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        bypass = 1'b0;
        @(posedge clk);
        #1;
        check("R1 valid in reset", out_valid, 1'b0);
        @(posedge clk);
        #1;
        check("R1 bit in reset", out_bit, 1'b0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic next_data(input int mode);
        prng = {prng[14:0], prng[15] ^ prng[13] ^ prng[12] ^ prng[10]};
        case (mode)
            0: return prng[0];
            1: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic encode(input logic d);
        logic s;
        s = d ^ enc_sh[3] ^ enc_sh[8];
        enc_sh = {enc_sh[7:0], s};
        enc_line = enc_line ^ s;
        return enc_line;
    endfunction

    // Encoded stream; decode checks from the 11th bit, fill checks before it
    task automatic run_stream(input int n, input logic [8:0] sh0, input logic line0,
                              input int mode, input int gap_every, input string req);
        logic d;
        logic t;
        logic held;
        enc_sh = sh0;
        enc_line = line0;
        for (int k = 1; k <= n; k++) begin
            if (gap_every != 0 && k % gap_every == 0) begin
                held = out_bit;
                push(1'b1, 1'b0, 1'b0);
                check("R5 gap no valid", out_valid, 1'b0);
                check("R5 gap holds bit", out_bit, held);
            end
            d = next_data(mode);
            t = encode(d);
            push(t, 1'b1, 1'b0);
            if (k <= 10) begin
                check("R4 fill window", out_valid, 1'b0);
            end else begin
                check("R3 valid after fill", out_valid, 1'b1);
                check(req, out_bit, d);
            end
        end
    endtask

    task automatic test_reset_state();
        do_reset();
        push(1'b1, 1'b0, 1'b0);
        check("R1 idle after reset", out_valid, 1'b0);
    endtask

    task automatic test_decode_random();
        do_reset();
        run_stream(200, 9'h1A5, 1'b0, 0, 0, "R2 random data");
    endtask

    task automatic test_decode_constant();
        do_reset();
        run_stream(60, 9'h000, 1'b0, 1, 0, "R2 all-zero data");
        do_reset();
        run_stream(60, 9'h0F3, 1'b1, 2, 0, "R2 all-one data");
    endtask

    task automatic test_polarity();
        do_reset();
        run_stream(80, 9'h155, 1'b1, 0, 0, "R7 inverted polarity");
        do_reset();
        run_stream(80, 9'h1FF, 1'b0, 0, 0, "R7 other encoder state");
    endtask

    task automatic test_gaps();
        do_reset();
        run_stream(120, 9'h0C9, 1'b0, 0, 3, "R5 data across gaps");
    endtask

    task automatic test_bypass();
        logic b;
        do_reset();
        for (int k = 0; k < 40; k++) begin
            b = next_data(0);
            if (k % 5 == 4) begin
                push(b, 1'b0, 1'b1);
                check("R6 bypass idle", out_valid, 1'b0);
            end else begin
                push(b, 1'b1, 1'b1);
                check("R6 bypass valid", out_valid, 1'b1);
                check("R6 bypass bit", out_bit, b);
            end
        end
        // Leaving bypass restarts the fill window (R4)
        run_stream(40, 9'h03C, 1'b1, 0, 0, "R4 decode after bypass exit");
    endtask

    task automatic test_mid_reset();
        do_reset();
        run_stream(30, 9'h111, 1'b0, 0, 0, "R2 before reset");
        do_reset();
        run_stream(30, 9'h0AA, 1'b0, 0, 0, "R1 refill after reset");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        prng = 16'hACE1;
        repeat (3) @(posedge clk);
        test_reset_state();
        test_decode_random();
        test_decode_constant();
        test_polarity();
        test_gaps();
        test_bypass();
        test_mid_reset();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule